// File: doc/BRIEF.md
# Tone Burst Transmit Sequencer

This block runs the transmit side of a dual-tone signalling transceiver. A host writes a 4-bit digit code through a one-cycle write strobe. The block then drives the enable and code inputs of an external tone generator. Tone synthesis and the receiver are outside this block. All timing is counted on a millisecond tick input.

In burst mode, each digit written while the sequencer is idle plays as one timed tone. A silent gap of the same length follows it. Both lengths double when the long-duration option is set. A ready flag goes high only once the gap has ended. In non-burst mode there is no timed sequence, and a direct gate input switches the tone on and off. Two mode inputs choose between dual-tone output and single-tone output, and for single-tone output they choose the low (row) or high (column) group.

Top module: `tone_burst_seq`

## Requirements
- R1: After reset, `tone_en`, `row_en`, `col_en`, `tx_ready` and `pause_done` are all 0 and `tone_code` is 0.
- R2: With `burst_off`=0, a `wr_digit` strobe seen while the sequencer is idle starts a burst. `tone_en` is 1 from the cycle after the strobe.
- R3: A normal burst lasts `BASE_TICKS` (default 51) tick pulses. A silent pause of the same number of ticks then follows, with `tone_en`=0.
- R4: If `long_mode` is 1 on the cycle of the starting write, the burst and the pause each last 2×`BASE_TICKS` (default 102) ticks. A change to `long_mode` after the start has no effect on that sequence.
- R5: `tx_ready` stays 0 during the burst and the pause. It goes to 1 only on the cycle after the last pause tick. A starting write clears it, and so does `burst_off`=1.
- R6: `pause_done` is high for exactly one cycle, and that cycle is the one in which `tx_ready` first rises.
- R7: A `wr_digit` strobe during a burst or a pause is ignored. `tone_code` keeps its value and the burst and pause timing does not change.
- R8: `wr_code` is latched on an accepted write and is shown on `tone_code` from the next cycle. In non-burst mode every write is accepted.
- R9: With `burst_off`=1, `tone_en` follows `tone_gate` in the same cycle. Setting `burst_off` to 1 ends any running sequence by the next cycle.
- R10: `single_sel`=0 makes `row_en` and `col_en` both equal to `tone_en`. With `single_sel`=1, `col_sel`=1 enables only `col_en` and `col_sel`=0 enables only `row_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| wr_digit | input | 1 | Digit write strobe |
| wr_code | input | 4 | Digit code to write |
| burst_off | input | 1 | 1 selects non-burst mode, 0 selects burst mode |
| long_mode | input | 1 | Doubles the burst and pause lengths |
| tone_gate | input | 1 | Direct tone gate used in non-burst mode |
| single_sel | input | 1 | 1 selects single-tone output, 0 selects dual-tone output |
| col_sel | input | 1 | In single-tone mode, 1 selects the column group and 0 the row group |
| tone_en | output | 1 | Tone generator enable |
| tone_code | output | 4 | Latched digit code |
| row_en | output | 1 | Row (low-group) oscillator enable |
| col_en | output | 1 | Column (high-group) oscillator enable |
| tx_ready | output | 1 | Transmitter ready for a new digit |
| pause_done | output | 1 | One-cycle pulse when the pause ends |

## Verification
Each result has a known latency:
- The sequence outputs (`tone_en` in burst mode, `tone_code`, `tx_ready` and `pause_done`) come from registers. They change one cycle after the write or tick that causes the change.
- The mode decode and the non-burst gate path are combinational. They change in the same cycle as their inputs.

The bench drives every input on the falling edge. It checks registered results on the next falling edge, after exactly one rising edge has taken the stimulus in. It checks combinational results a short delay after the inputs change, with no clock edge in between.

Tick pulses are driven one at a time, each with a known edge, so the bench can check a burst one tick before its end and again on the tick that ends it. This pins the length to an exact tick count.

// File: rtl/tone_burst_seq.sv
module tone_burst_seq #(
  parameter int CODE_W     = 4,
  parameter int BASE_TICKS = 51
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              wr_digit,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              burst_off,
  input  logic              long_mode,
  input  logic              tone_gate,
  input  logic              single_sel,
  input  logic              col_sel,
  output logic              tone_en,
  output logic [CODE_W-1:0] tone_code,
  output logic              row_en,
  output logic              col_en,
  output logic              tx_ready,
  output logic              pause_done
);
  localparam int LONG_TICKS = 2 * BASE_TICKS;
  localparam int CNT_W = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(BASE_TICKS);
  localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_TICKS);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_PAUSE} seq_t;

  seq_t              state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  dur_q;
  logic [CODE_W-1:0] code_q;
  logic              last_tick;

  assign last_tick = tick_ms && (cnt == dur_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      dur_q      <= SHORT_LEN;
      code_q     <= '0;
      tx_ready   <= 1'b0;
      pause_done <= 1'b0;
    end else begin
      pause_done <= 1'b0;
      if (wr_digit && (burst_off || state == S_IDLE))
        code_q <= wr_code;
      if (burst_off) begin
        state    <= S_IDLE;
        cnt      <= '0;
        tx_ready <= 1'b0;
      end else begin
        case (state)
          S_IDLE: if (wr_digit) begin
            state    <= S_BURST;
            cnt      <= '0;
            dur_q    <= long_mode ? LONG_LEN : SHORT_LEN;
            tx_ready <= 1'b0;
          end
          S_BURST: if (last_tick) begin
            state <= S_PAUSE;
            cnt   <= '0;
          end else if (tick_ms) begin
            cnt <= cnt + CNT_W'(1);
          end
          S_PAUSE: if (last_tick) begin
            state      <= S_IDLE;
            cnt        <= '0;
            pause_done <= 1'b1;
            tx_ready   <= 1'b1;
          end else if (tick_ms) begin
            cnt <= cnt + CNT_W'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign tone_code = code_q;
  assign tone_en   = burst_off ? tone_gate : (state == S_BURST);
  assign row_en    = tone_en && (!single_sel || !col_sel);
  assign col_en    = tone_en && (!single_sel || col_sel);

  assert_ready_after_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> ($past(state) == S_PAUSE && !$past(burst_off)));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> !pause_done);

  assert_done_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |-> tx_ready);

  assert_code_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !burst_off) |=> $stable(tone_code));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> (cnt < dur_q));

  assert_nonburst_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_off |=> (state == S_IDLE && !tx_ready));

  assert_len_choice_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dur_q == SHORT_LEN) || (dur_q == LONG_LEN));
endmodule

// File: tb/tone_burst_seq_test.sv
module tone_burst_seq_test;
  logic clk = 0, rst_n = 0, tick_ms = 0, wr_digit = 0;
  logic [3:0] wr_code = 0;
  logic burst_off = 0, long_mode = 0, tone_gate = 0, single_sel = 0, col_sel = 0;
  logic tone_en, row_en, col_en, tx_ready, pause_done;
  logic [3:0] tone_code;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  tone_burst_seq uut (.*);

  // {tone_gate, single_sel, col_sel} -> {tone_en, row_en, col_en}
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_000, 6'b011_000,
    6'b100_111, 6'b101_111, 6'b110_110, 6'b111_101};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1;
      @(negedge clk) tick_ms = 0;
    end
  endtask

  task automatic wr(logic [3:0] c);
    @(negedge clk) begin wr_digit = 1; wr_code = c; end
    @(negedge clk) wr_digit = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 tone_en", tone_en, 0); chk("R1 tx_ready", tx_ready, 0);
    chk("R1 pause_done", pause_done, 0); chk("R1 code", tone_code, 0);
    chk("R1 row_en", row_en, 0); chk("R1 col_en", col_en, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9/R10: decode table in non-burst mode
    burst_off = 1;
    for (int i = 0; i < 8; i++) begin
      {tone_gate, single_sel, col_sel} = VEC[i][5:3];
      #1;
      chk("R9/R10 decode", {tone_en, row_en, col_en}, VEC[i][2:0]);
    end
    tone_gate = 0; single_sel = 0; col_sel = 0;

    // R8: non-burst write latched
    wr(4'hA);
    chk("R8 nonburst latch", tone_code, 4'hA);
    chk("R9 no sequence", tone_en, 0);

    // R2/R3/R5/R6/R7: short burst
    @(negedge clk) burst_off = 0;
    wr(4'h5);
    chk("R2 tone on", tone_en, 1); chk("R8 code", tone_code, 4'h5);
    chk("R5 ready low in burst", tx_ready, 0);
    long_mode = 1;
    wr(4'h9);
    chk("R7 code held", tone_code, 4'h5);
    ticks(50);
    chk("R3 burst before end", tone_en, 1);
    ticks(1);
    chk("R3 burst end", tone_en, 0); chk("R5 ready low in pause", tx_ready, 0);
    wr(4'h3);
    chk("R7 pause write ignored", tone_code, 4'h5);
    chk("R7 no restart", tone_en, 0);
    ticks(50);
    chk("R3 pause before end", tx_ready, 0); chk("R6 no early done", pause_done, 0);
    ticks(1);
    chk("R5 ready at pause end", tx_ready, 1); chk("R6 done pulse", pause_done, 1);
    @(negedge clk);
    chk("R6 done one cycle", pause_done, 0); chk("R5 ready held", tx_ready, 1);

    // R4: long burst, single tone column
    single_sel = 1; col_sel = 1;
    wr(4'hC);
    chk("R5 ready cleared by write", tx_ready, 0);
    chk("R10 single col", {row_en, col_en}, 2'b01);
    long_mode = 0;
    ticks(101);
    chk("R4 long burst before end", tone_en, 1);
    ticks(1);
    chk("R4 long burst end", tone_en, 0);
    ticks(101);
    chk("R4 long pause before end", tx_ready, 0);
    ticks(1);
    chk("R4 long pause end", tx_ready, 1); chk("R6 long done", pause_done, 1);

    // R5/R9: non-burst clears ready and aborts
    @(negedge clk) burst_off = 1;
    @(negedge clk);
    chk("R5 ready cleared nonburst", tx_ready, 0);
    burst_off = 0; single_sel = 0;
    wr(4'h7);
    chk("R2 second burst", tone_en, 1);
    ticks(10);
    @(negedge clk) burst_off = 1; tone_gate = 0;
    #1 chk("R9 abort tone", tone_en, 0);
    @(negedge clk) burst_off = 0;
    #1 chk("R9 sequence ended", tone_en, 0);
    ticks(60);
    chk("R9 no ready after abort", tx_ready, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule